// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible side of a multi-channel DMA controller. A single 32-bit register window carries a bank of registers for each channel plus two global words: a channel enable mask and a read-only summary of pending interrupts. The channel number comes from address bits 11:8 and the register from bits 7:0. This applies to every offset below 0xF00. The two globals sit at fixed offsets near the top of the 4 KiB window. The block does not move data. It sends a one-cycle launch pulse to a channel engine and takes back that engine's completion pulses and descriptor contents. It presents the descriptor contents as read-only registers.

Each channel's control/status word combines three kinds of bits. Some are plain read/write bits, replaced on every write. Some are write-one-to-clear flags (END and INT). One is a self-clearing reset command. Each channel has a small sequencer with the states CH_STOPPED, CH_LAUNCH and CH_BUSY. From CH_STOPPED, a write that raises ACTIVE from 0 to 1 on an enabled channel moves it to CH_LAUNCH. CH_LAUNCH always moves to CH_BUSY after one cycle, and the start pulse is high during that cycle. CH_BUSY returns to CH_STOPPED on an engine completion or on a reset command. The bus side has two states, BUS_IDLE and BUS_RESP. Any read request moves it to BUS_RESP for the following cycle, and a cycle with no read returns it to BUS_IDLE.

Top module: `dmafe_regs_top`

## Requirements
- R1: For word-aligned offsets below 0xF00, bits 11:8 select the channel and bits 7:0 select its register. Within a channel, 0x00 is control/status, 0x04 is the descriptor address (read/write) and 0x20 is a scratch debug word (read/write). Writing one channel's register leaves every other channel unchanged.
- R2: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C return the engine's current info, source, destination, length, stride and next-descriptor words for the channel. Writes to these offsets have no effect.
- R3: Offset 0xFF0 is the channel enable mask. It is NUM_CH bits wide, resets to all ones, is loaded from the low bits of a write, and is driven on `chan_enable`. A channel whose enable bit is 0 never receives a start pulse.
- R4: Offset 0xFE0 returns one interrupt-pending bit per channel. A bit is set in the same cycle as that channel's INT flag. Writes to 0xFE0 have no effect.
- R5: A control/status write with bit 31 set clears that channel's control/status word and descriptor address before the write's read/write bits are applied. Bit 31 always reads 0.
- R6: In a control/status write, a 1 in bit 1 clears END and a 1 in bit 2 clears INT, clears the channel's pending bit at 0xFE0 and drops its `irq` line. `irq` is a level equal to the INT flag.
- R7: Control/status bits in mask 0x30FF0001 (bit 0 ACTIVE, bits 23:16, bits 29:28) are replaced by the written value on every control/status write. Bit 30 (abort) has no effect and reads 0.
- R8: A control/status write that takes ACTIVE from 0 to 1 on an enabled channel raises that channel's `chan_start` for exactly one cycle, in the cycle after the write. A write that finds ACTIVE already set does not launch.
- R9: An `eng_done` pulse on a channel in CH_BUSY has these effects: it clears ACTIVE, sets END (bit 1) and the paused flag (bit 4), sets INT (bit 2) when info bit 0 is 1, and loads the descriptor address from the next-descriptor word. A pulse in any other state is ignored.
- R10: Reads of undefined or non-word-aligned offsets, including channel indices of NUM_CH or more, return zero. Writes to them change nothing.
- R11: A read request returns its data with `resp_valid` high in the next cycle. `resp_valid` is low in every cycle that does not follow a read request.
- R12: After reset, the interrupt status and every channel's control/status word, descriptor address and debug word are zero. `chan_start` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Read data valid (cycle after a read request) |
| resp_rdata | output | 32 | Read data |
| chan_start | output | NUM_CH | One-cycle launch pulse per channel |
| chan_enable | output | NUM_CH | Channel enable mask |
| eng_done | input | NUM_CH | Engine completion pulse per channel |
| eng_info | input | NUM_CH*32 | Current info word per channel |
| eng_src | input | NUM_CH*32 | Current source address per channel |
| eng_dst | input | NUM_CH*32 | Current destination address per channel |
| eng_len | input | NUM_CH*32 | Current transfer length per channel |
| eng_stride | input | NUM_CH*32 | Current stride per channel |
| eng_next | input | NUM_CH*32 | Next descriptor address per channel |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
Several properties are checked on every cycle. A start pulse lasts one cycle and always follows an ACTIVE write. A clear of INT drops `irq`, and a reset command zeroes the descriptor address. An engine completion leaves END and paused set with ACTIVE clear. A pending bit rises with INT and otherwise holds. No channel starts while disabled, and `resp_valid` follows read requests exactly. The field masking of whole words can only be shown by the bench's scenarios. These include the value read back after mixed writes, the ignored abort and summary writes, undefined and misaligned offsets, and the descriptor address loaded from the next-descriptor word.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

    localparam int REG_W = 32;

    // control/status bit positions (software-visible layout)
    localparam int CS_ACTIVE = 0;
    localparam int CS_END    = 1;
    localparam int CS_INT    = 2;
    localparam int CS_PAUSED = 4;
    localparam int CS_ABORT  = 30;
    localparam int CS_RESET  = 31;

    localparam logic [REG_W-1:0] CS_RW_MASK = 32'h30FF_0001;

    localparam logic [11:0] CHAN_LIMIT  = 12'hF00;
    localparam logic [11:0] OFS_INTSTAT = 12'hFE0;
    localparam logic [11:0] OFS_ENABLE  = 12'hFF0;

    typedef enum logic [1:0] {
        AK_NONE,
        AK_CHAN,
        AK_INTSTAT,
        AK_ENABLE
    } acc_kind_e;

    typedef enum logic [3:0] {
        RG_CS,
        RG_CBADDR,
        RG_INFO,
        RG_SRC,
        RG_DST,
        RG_LEN,
        RG_STRIDE,
        RG_NEXT,
        RG_DEBUG,
        RG_NONE
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    typedef enum logic [1:0] {
        CH_STOPPED,
        CH_LAUNCH,
        CH_BUSY
    } chan_state_e;

endpackage

// File: rtl/dmafe_decode.sv
module dmafe_decode
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [11:0] addr,
    output acc_kind_e   kind,
    output logic [3:0]  chan_idx,
    output reg_sel_e    reg_sel
);

    logic aligned;
    logic chan_ok;

    assign aligned  = (addr[1:0] == 2'b00);
    assign chan_idx = addr[11:8];
    assign chan_ok  = (int'(addr[11:8]) < NUM_CH);

    always_comb begin
        reg_sel = RG_NONE;
        unique case (addr[7:0])
            8'h00:   reg_sel = RG_CS;
            8'h04:   reg_sel = RG_CBADDR;
            8'h08:   reg_sel = RG_INFO;
            8'h0C:   reg_sel = RG_SRC;
            8'h10:   reg_sel = RG_DST;
            8'h14:   reg_sel = RG_LEN;
            8'h18:   reg_sel = RG_STRIDE;
            8'h1C:   reg_sel = RG_NEXT;
            8'h20:   reg_sel = RG_DEBUG;
            default: reg_sel = RG_NONE;
        endcase
    end

    always_comb begin
        kind = AK_NONE;
        if (aligned) begin
            if (addr < CHAN_LIMIT) begin
                if (chan_ok && (reg_sel != RG_NONE)) begin
                    kind = AK_CHAN;
                end
            end else if (addr == OFS_INTSTAT) begin
                kind = AK_INTSTAT;
            end else if (addr == OFS_ENABLE) begin
                kind = AK_ENABLE;
            end
        end
    end

endmodule

// File: rtl/dmafe_chan_regs.sv
module dmafe_chan_regs
    import dmafe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cs,
    input  logic             wr_cb,
    input  logic             wr_dbg,
    input  logic [REG_W-1:0] wdata,
    input  logic             chan_en,
    input  logic             eng_done,
    input  logic             info_int_en,
    input  logic [REG_W-1:0] next_desc,
    output logic [REG_W-1:0] cs_q,
    output logic [REG_W-1:0] cb_q,
    output logic [REG_W-1:0] dbg_q,
    output logic             start,
    output logic             irq,
    output logic             int_set,
    output logic             int_clr
);

    chan_state_e      state_q, state_d;
    logic [REG_W-1:0] cs_d, cb_d;
    logic             done_ok;
    logic             launch;
    logic             rst_cmd;

    assign done_ok = eng_done && (state_q == CH_BUSY);
    assign rst_cmd = wr_cs && wdata[CS_RESET];

    // next control/status and descriptor address
    always_comb begin
        cs_d = cs_q;
        cb_d = cb_q;
        if (done_ok) begin
            cs_d[CS_ACTIVE] = 1'b0;
            cs_d[CS_END]    = 1'b1;
            cs_d[CS_PAUSED] = 1'b1;
            if (info_int_en) begin
                cs_d[CS_INT] = 1'b1;
            end
            cb_d = next_desc;
        end
        if (wr_cs) begin
            if (wdata[CS_RESET]) begin
                cs_d = '0;
                cb_d = '0;
            end
            if (wdata[CS_END]) begin
                cs_d[CS_END] = 1'b0;
            end
            if (wdata[CS_INT]) begin
                cs_d[CS_INT] = 1'b0;
            end
            cs_d = (cs_d & ~CS_RW_MASK) | (wdata & CS_RW_MASK);
        end
        if (wr_cb) begin
            cb_d = wdata;
        end
    end

    assign launch = wr_cs && !cs_q[CS_ACTIVE] && cs_d[CS_ACTIVE] && chan_en;

    // sequencer next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: if (launch) state_d = CH_LAUNCH;
            CH_LAUNCH:  state_d = CH_BUSY;
            CH_BUSY:    if (done_ok || rst_cmd) state_d = CH_STOPPED;
            default:    state_d = CH_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            cb_q  <= '0;
            dbg_q <= '0;
        end else begin
            cs_q <= cs_d;
            cb_q <= cb_d;
            if (wr_dbg) begin
                dbg_q <= wdata;
            end
        end
    end

    // outputs
    always_comb begin
        start   = (state_q == CH_LAUNCH);
        irq     = cs_q[CS_INT];
        int_set = done_ok && info_int_en;
        int_clr = wr_cs && wdata[CS_INT];
    end

    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    p_start_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr_cs && wdata[CS_ACTIVE]));

    p_int_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cs && wdata[CS_INT]) |=> !irq);

    p_reset_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (cb_q == '0) && !cs_q[CS_END]);

    p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !wr_cs) |=> cs_q[CS_END] && cs_q[CS_PAUSED] && !cs_q[CS_ACTIVE]);

endmodule

// File: rtl/dmafe_globals.sv
module dmafe_globals
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] int_set,
    input  logic [NUM_CH-1:0] int_clr,
    output logic [NUM_CH-1:0] enable_q,
    output logic [NUM_CH-1:0] int_status_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q     <= '1;
            int_status_q <= '0;
        end else begin
            if (wr_enable) begin
                enable_q <= wdata;
            end
            int_status_q <= (int_status_q & ~int_clr) | int_set;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_intstat_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            int_set[c] |=> int_status_q[c]);

        p_intstat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!int_set[c] && !int_clr[c]) |=> (int_status_q[c] == $past(int_status_q[c])));
    end

endmodule

// File: rtl/dmafe_regs_top.sv
module dmafe_regs_top
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [11:0]             req_addr,
    input  logic [31:0]             req_wdata,
    output logic                    resp_valid,
    output logic [31:0]             resp_rdata,
    output logic [NUM_CH-1:0]       chan_start,
    output logic [NUM_CH-1:0]       chan_enable,
    input  logic [NUM_CH-1:0]       eng_done,
    input  logic [NUM_CH*32-1:0]    eng_info,
    input  logic [NUM_CH*32-1:0]    eng_src,
    input  logic [NUM_CH*32-1:0]    eng_dst,
    input  logic [NUM_CH*32-1:0]    eng_len,
    input  logic [NUM_CH*32-1:0]    eng_stride,
    input  logic [NUM_CH*32-1:0]    eng_next,
    output logic [NUM_CH-1:0]       irq
);

    localparam int VIEW_W = NUM_CH * REG_W;

    acc_kind_e   kind;
    reg_sel_e    reg_sel;
    logic [3:0]  chan_idx;
    logic        wr, rd;

    logic [REG_W-1:0] cs_arr  [NUM_CH];
    logic [REG_W-1:0] cb_arr  [NUM_CH];
    logic [REG_W-1:0] dbg_arr [NUM_CH];
    logic [NUM_CH-1:0] int_set, int_clr;
    logic [NUM_CH-1:0] enable_q, int_status_q;

    bus_state_e       bus_q, bus_d;
    logic [REG_W-1:0] rdata_d, rdata_q;

    assign wr = req_valid && req_write;
    assign rd = req_valid && !req_write;

    dmafe_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr     (req_addr),
        .kind     (kind),
        .chan_idx (chan_idx),
        .reg_sel  (reg_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic sel;
        assign sel = wr && (kind == AK_CHAN) && (chan_idx == 4'(c));

        dmafe_chan_regs u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_cs       (sel && (reg_sel == RG_CS)),
            .wr_cb       (sel && (reg_sel == RG_CBADDR)),
            .wr_dbg      (sel && (reg_sel == RG_DEBUG)),
            .wdata       (req_wdata),
            .chan_en     (enable_q[c]),
            .eng_done    (eng_done[c]),
            .info_int_en (eng_info[c*REG_W]),
            .next_desc   (eng_next[c*REG_W +: REG_W]),
            .cs_q        (cs_arr[c]),
            .cb_q        (cb_arr[c]),
            .dbg_q       (dbg_arr[c]),
            .start       (chan_start[c]),
            .irq         (irq[c]),
            .int_set     (int_set[c]),
            .int_clr     (int_clr[c])
        );

        p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
            chan_start[c] |-> $past(enable_q[c]));
    end

    dmafe_globals #(.NUM_CH(NUM_CH)) u_globals (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_enable    (wr && (kind == AK_ENABLE)),
        .wdata        (req_wdata[NUM_CH-1:0]),
        .int_set      (int_set),
        .int_clr      (int_clr),
        .enable_q     (enable_q),
        .int_status_q (int_status_q)
    );

    assign chan_enable = enable_q;

    // read data selection
    always_comb begin
        logic [REG_W-1:0] v_cs, v_cb, v_dbg, v_info, v_src, v_dst, v_len, v_str, v_nxt;
        v_cs = '0; v_cb = '0; v_dbg = '0; v_info = '0; v_src = '0;
        v_dst = '0; v_len = '0; v_str = '0; v_nxt = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_idx == 4'(c)) begin
                v_cs   = cs_arr[c];
                v_cb   = cb_arr[c];
                v_dbg  = dbg_arr[c];
                v_info = eng_info[c*REG_W +: REG_W];
                v_src  = eng_src[c*REG_W +: REG_W];
                v_dst  = eng_dst[c*REG_W +: REG_W];
                v_len  = eng_len[c*REG_W +: REG_W];
                v_str  = eng_stride[c*REG_W +: REG_W];
                v_nxt  = eng_next[c*REG_W +: REG_W];
            end
        end
        rdata_d = '0;
        unique case (kind)
            AK_INTSTAT: rdata_d = REG_W'(int_status_q);
            AK_ENABLE:  rdata_d = REG_W'(enable_q);
            AK_CHAN: begin
                unique case (reg_sel)
                    RG_CS:     rdata_d = v_cs;
                    RG_CBADDR: rdata_d = v_cb;
                    RG_INFO:   rdata_d = v_info;
                    RG_SRC:    rdata_d = v_src;
                    RG_DST:    rdata_d = v_dst;
                    RG_LEN:    rdata_d = v_len;
                    RG_STRIDE: rdata_d = v_str;
                    RG_NEXT:   rdata_d = v_nxt;
                    RG_DEBUG:  rdata_d = v_dbg;
                    default:   rdata_d = '0;
                endcase
            end
            default: rdata_d = '0;
        endcase
    end

    // bus sequencer next state
    always_comb begin
        bus_d = bus_q;
        unique case (bus_q)
            BUS_IDLE: bus_d = rd ? BUS_RESP : BUS_IDLE;
            BUS_RESP: bus_d = rd ? BUS_RESP : BUS_IDLE;
            default:  bus_d = BUS_IDLE;
        endcase
    end

    // state register and read data latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q   <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            bus_q <= bus_d;
            if (rd) begin
                rdata_q <= rdata_d;
            end
        end
    end

    // outputs
    always_comb begin
        resp_valid = (bus_q == BUS_RESP);
        resp_rdata = resp_valid ? rdata_q : '0;
    end

    p_resp_follows_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> resp_valid);

    p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !resp_valid);

endmodule

// File: tb/dmafe_regs_top_test.sv
module dmafe_regs_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [11:0]          req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic                 resp_valid;
    logic [31:0]          resp_rdata;
    logic [NUM_CH-1:0]    chan_start;
    logic [NUM_CH-1:0]    chan_enable;
    logic [NUM_CH-1:0]    eng_done = '0;
    logic [NUM_CH*32-1:0] eng_info = '0;
    logic [NUM_CH*32-1:0] eng_src = '0;
    logic [NUM_CH*32-1:0] eng_dst = '0;
    logic [NUM_CH*32-1:0] eng_len = '0;
    logic [NUM_CH*32-1:0] eng_stride = '0;
    logic [NUM_CH*32-1:0] eng_next = '0;
    logic [NUM_CH-1:0]    irq;

    int    n_checks = 0;
    int    n_errors = 0;
    logic  finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmafe_regs_top #(.NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .chan_start(chan_start), .chan_enable(chan_enable),
        .eng_done(eng_done), .eng_info(eng_info), .eng_src(eng_src),
        .eng_dst(eng_dst), .eng_len(eng_len), .eng_stride(eng_stride),
        .eng_next(eng_next), .irq(irq)
    );

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_done(input int c);
        @(negedge clk);
        eng_done[c] = 1'b1;
        @(negedge clk);
        eng_done = '0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (resp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected response", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), resp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        eng_info[2*32 +: 32]   = 32'h0000_0A11;
        eng_src[2*32 +: 32]    = 32'h1111_0000;
        eng_dst[2*32 +: 32]    = 32'h2222_0000;
        eng_len[2*32 +: 32]    = 32'h0000_0400;
        eng_stride[2*32 +: 32] = 32'h0010_0020;
        eng_next[2*32 +: 32]   = 32'h0000_5000;
        eng_info[4*32 +: 32]   = 32'h0000_0001;
        eng_next[4*32 +: 32]   = 32'h0000_2000;
        eng_info[5*32 +: 32]   = 32'h0000_0000;
        eng_next[5*32 +: 32]   = 32'h0000_3000;
        eng_info[6*32 +: 32]   = 32'h0000_0001;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        @(negedge clk);
        chk("R12 start idle", 32'(chan_start), 32'h0);
        chk("R12 irq idle", 32'(irq), 32'h0);
        chk("R11 no response when idle", 32'(resp_valid), 32'h0);
        bus_read(12'hFF0, 32'h0000_FFFF, "R3 enable reset value");
        bus_read(12'hFE0, 32'h0, "R12 int status reset");
        bus_read(12'h000, 32'h0, "R12 cs reset");
        bus_read(12'h004, 32'h0, "R12 cb reset");
        bus_read(12'h720, 32'h0, "R12 debug reset");

        // R1 decode and per-channel storage
        bus_write(12'h304, 32'hABCD_0010);
        bus_write(12'h320, 32'h1234_5678);
        bus_read(12'h304, 32'hABCD_0010, "R1 cb ch3");
        bus_read(12'h320, 32'h1234_5678, "R1 debug ch3");
        bus_read(12'h204, 32'h0, "R1 cb ch2 untouched");

        // R2 descriptor views
        bus_read(12'h208, 32'h0000_0A11, "R2 info");
        bus_read(12'h20C, 32'h1111_0000, "R2 src");
        bus_read(12'h210, 32'h2222_0000, "R2 dst");
        bus_read(12'h214, 32'h0000_0400, "R2 len");
        bus_read(12'h218, 32'h0010_0020, "R2 stride");
        bus_read(12'h21C, 32'h0000_5000, "R2 next");
        bus_write(12'h20C, 32'hDEAD_BEEF);
        bus_read(12'h20C, 32'h1111_0000, "R2 view write ignored");
        bus_read(12'h204, 32'h0, "R2 view write no side effect");

        // R7 read/write mask
        bus_write(12'h100, 32'h4FFF_FFF6);
        chk("R7 no launch without ACTIVE", 32'(chan_start), 32'h0);
        bus_read(12'h100, 32'h00FF_0000, "R7 masked write");
        bus_write(12'h100, 32'h3000_0000);
        bus_read(12'h100, 32'h3000_0000, "R7 replaced");
        bus_write(12'h100, 32'h0);

        // R8 launch
        bus_write(12'h400, 32'h1);
        chk("R8 start pulse", 32'(chan_start), 32'h0000_0010);
        @(negedge clk);
        chk("R8 start one cycle", 32'(chan_start), 32'h0);
        bus_read(12'h400, 32'h1, "R8 ACTIVE set");
        bus_write(12'h400, 32'h1);
        chk("R8 no relaunch", 32'(chan_start), 32'h0);

        // R9 completion with interrupt
        pulse_done(4);
        chk("R9 irq raised", 32'(irq), 32'h0000_0010);
        bus_read(12'h400, 32'h16, "R9 cs after done");
        bus_read(12'hFE0, 32'h10, "R4 pending bit");
        bus_read(12'h404, 32'h2000, "R9 cb from next");

        // R6 write-one-to-clear
        bus_write(12'h400, 32'h2);
        bus_read(12'h400, 32'h14, "R6 END cleared");
        chk("R6 irq held", 32'(irq), 32'h0000_0010);
        bus_write(12'h400, 32'h4);
        chk("R6 irq dropped", 32'(irq), 32'h0);
        bus_read(12'h400, 32'h10, "R6 INT cleared");
        bus_read(12'hFE0, 32'h0, "R6 pending cleared");

        // R9 completion without interrupt, done ignored when stopped
        pulse_done(5);
        bus_read(12'h500, 32'h0, "R9 done ignored when stopped");
        bus_write(12'h500, 32'h1);
        chk("R8 start ch5", 32'(chan_start), 32'h0000_0020);
        @(negedge clk);
        pulse_done(5);
        chk("R9 no irq", 32'(irq), 32'h0);
        bus_read(12'h500, 32'h12, "R9 cs no int");
        bus_read(12'hFE0, 32'h0, "R9 no pending");
        bus_read(12'h504, 32'h3000, "R9 cb ch5");

        // R5 reset command
        bus_write(12'h500, 32'h8000_0000);
        bus_read(12'h500, 32'h0, "R5 cs cleared");
        bus_read(12'h504, 32'h0, "R5 cb cleared");

        // R3 enable mask gating
        bus_write(12'hFF0, 32'hFFFF_FFEF);
        bus_read(12'hFF0, 32'h0000_FFEF, "R3 enable write");
        chk("R3 enable port", 32'(chan_enable), 32'h0000_FFEF);
        bus_write(12'h400, 32'h1);
        chk("R3 disabled no start", 32'(chan_start), 32'h0);
        bus_read(12'h400, 32'h11, "R3 ACTIVE still stored");
        bus_write(12'hFF0, 32'h0000_FFFF);

        // R4 summary write ignored
        bus_write(12'h600, 32'h1);
        chk("R8 start ch6", 32'(chan_start), 32'h0000_0040);
        @(negedge clk);
        pulse_done(6);
        bus_write(12'hFE0, 32'h0);
        bus_read(12'hFE0, 32'h40, "R4 write ignored");
        chk("R4 irq ch6", 32'(irq), 32'h0000_0040);

        // R10 undefined and misaligned
        bus_read(12'h024, 32'h0, "R10 undefined chan offset");
        bus_read(12'hF04, 32'h0, "R10 undefined global");
        bus_read(12'h306, 32'h0, "R10 misaligned read");
        bus_write(12'h305, 32'h5555_5555);
        bus_read(12'h304, 32'hABCD_0010, "R10 misaligned write ignored");
        bus_write(12'hF80, 32'h0);
        bus_read(12'hFF0, 32'h0000_FFFF, "R10 undefined write ignored");

        // R7 abort bit has no effect
        bus_write(12'h700, 32'h4000_0000);
        chk("R7 abort no start", 32'(chan_start), 32'h0);
        bus_read(12'h700, 32'h0, "R7 abort reads zero");

        repeat (3) @(negedge clk);
        chk("R11 all responses seen", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule